// File: doc/BRIEF.md
# Aliased Integer Register File

This block holds the integer register state of a 64-bit RISC core: a bank of `NREGS` registers, each `XLEN` bits wide, with two combinational read ports and one synchronous main write port. The main port writes either a full register or a narrow word. A narrow word is sign-extended to full width before it is stored. Either read port can return the full register or only its low half, zero-extended. The last register is a constant zero and holds no storage.

A few fixed registers also serve as narrower architectural registers through dedicated side ports. One register is a multiply accumulator split into a high word and a low word. Bit 0 of another register is a single condition flag. Three more registers act as 32-bit base and return-address registers. Side writes merge into the stored register: an accumulator half replaces only its own half, a flag write replaces only bit 0, and a base-register write stores a sign-extended word. If a side write and the main write target the same register in one cycle, the main write takes effect and `clash` is raised for that cycle.

Top module: `alias_regfile`

## Requirements
- R1: Register 63 (`ZERO_IDX`) reads as zero on both read ports in both read widths. Writes to it, full or narrow, have no effect.
- R2: A main write (`wr_en`=1, `wr_narrow`=0) stores `wr_data` into `wr_addr` at the rising clock edge. A read of that register in the same cycle returns the value it held before the write.
- R3: A narrow main write (`wr_narrow`=1) stores `wr_data[31:0]` sign-extended to 64 bits.
- R4: A narrow read (`rd_x_narrow`=1) returns bits 31:0 of the register, with bits 63:32 forced to zero. A full read returns all 64 bits.
- R5: Register 17 holds the accumulator. `acc_hi_q`/`acc_lo_q` show bits 63:32 and 31:0 of it. A high write replaces only bits 63:32, a low write replaces only bits 31:0, and both may be written in the same cycle.
- R6: The flag is bit 0 of register 19 and appears on `tflag_q`. A flag write changes only that bit and leaves bits 63:1 unchanged.
- R7: Registers 16, 18 and 20 are the global-base, return and vector-base registers. Their side outputs show bits 31:0, and a side write stores the 32-bit value sign-extended to 64 bits.
- R8: When a side write and the main write target the same register in one cycle, only the main write is applied and `clash` is 1 during that cycle. In every other case `clash` is 0, and side and main writes to different registers are all applied.
- R9: While `rst` is high at a rising edge, all registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Main write enable |
| wr_narrow | input | 1 | 1: store sign-extended low word; 0: store full word |
| wr_addr | input | 6 | Main write register index |
| wr_data | input | 64 | Main write data |
| rd_a_addr | input | 6 | Read port A register index |
| rd_a_narrow | input | 1 | Read port A low-word mode |
| rd_a_data | output | 64 | Read port A data |
| rd_b_addr | input | 6 | Read port B register index |
| rd_b_narrow | input | 1 | Read port B low-word mode |
| rd_b_data | output | 64 | Read port B data |
| acc_hi_we | input | 1 | Accumulator high-word write enable |
| acc_hi_wd | input | 32 | Accumulator high-word write data |
| acc_lo_we | input | 1 | Accumulator low-word write enable |
| acc_lo_wd | input | 32 | Accumulator low-word write data |
| tflag_we | input | 1 | Flag write enable |
| tflag_wd | input | 1 | Flag write value |
| gbase_we | input | 1 | Global-base write enable |
| gbase_wd | input | 32 | Global-base write data |
| ret_we | input | 1 | Return-register write enable |
| ret_wd | input | 32 | Return-register write data |
| vbase_we | input | 1 | Vector-base write enable |
| vbase_wd | input | 32 | Vector-base write data |
| acc_hi_q | output | 32 | Accumulator high word |
| acc_lo_q | output | 32 | Accumulator low word |
| tflag_q | output | 1 | Flag value |
| gbase_q | output | 32 | Global-base low word |
| ret_q | output | 32 | Return-register low word |
| vbase_q | output | 32 | Vector-base low word |
| clash | output | 1 | Main and side writes collide this cycle |

## Verification
Read data, the side outputs and `clash` are combinational, so they are due in the same cycle as their inputs. A write becomes visible one rising edge after the cycle that carries it. The bench drives each stimulus at a falling edge and samples the same-cycle results (the old value on the written register, and `clash`) one nanosecond later, before the next rising edge. Every stored effect is checked through the read ports or side outputs after that rising edge has passed. Full sweeps over all 64 registers in both write widths and both read widths are compared against a bench-side model built from the requirements.

// File: rtl/arf_pkg.sv
package arf_pkg;
   // Side-write lanes; each lane targets exactly one fixed register.
   localparam int unsigned SIDE_LANES = 5;
   localparam int unsigned LANE_ACC   = 0;
   localparam int unsigned LANE_FLAG  = 1;
   localparam int unsigned LANE_GBASE = 2;
   localparam int unsigned LANE_RET   = 3;
   localparam int unsigned LANE_VBASE = 4;
   // The three word-wide alias lanes sit next to each other from LANE_GBASE.
   localparam int unsigned WIDE_LANES = 3;
endpackage

// File: rtl/arf_side_merge.sv
module arf_side_merge
   import arf_pkg::*;
#(
   parameter int unsigned XLEN = 64,
   parameter int unsigned HALF = 32
) (
   input  logic [XLEN-1:0]   acc_cur,
   input  logic [XLEN-1:1]   flag_keep,
   input  logic              acc_hi_we,
   input  logic [HALF-1:0]   acc_hi_wd,
   input  logic              acc_lo_we,
   input  logic [HALF-1:0]   acc_lo_wd,
   input  logic              flag_we,
   input  logic              flag_wd,
   input  logic [WIDE_LANES-1:0] wide_we,
   input  logic [HALF-1:0]   wide_wd [WIDE_LANES],
   output logic [SIDE_LANES-1:0] lane_en,
   output logic [XLEN-1:0]   lane_data [SIDE_LANES]
);
   localparam int unsigned EXT = XLEN - HALF;

   // Accumulator: each half is replaced only when its own enable is set.
   assign lane_en[LANE_ACC]   = acc_hi_we | acc_lo_we;
   assign lane_data[LANE_ACC] = {acc_hi_we ? acc_hi_wd : acc_cur[XLEN-1:HALF],
                                 acc_lo_we ? acc_lo_wd : acc_cur[HALF-1:0]};

   // Flag: bit 0 replaced, upper bits carried over.
   assign lane_en[LANE_FLAG]   = flag_we;
   assign lane_data[LANE_FLAG] = {flag_keep, flag_wd};

   // Word-wide aliases: sign-extended store.
   for (genvar k = 0; k < WIDE_LANES; k++) begin : g_wide
      assign lane_en[LANE_GBASE+k]   = wide_we[k];
      assign lane_data[LANE_GBASE+k] = {{EXT{wide_wd[k][HALF-1]}}, wide_wd[k]};
   end
endmodule

// File: rtl/arf_storage.sv
module arf_storage #(
   parameter int unsigned NREGS    = 64,
   parameter int unsigned XLEN     = 64,
   parameter int unsigned AW       = 6,
   parameter int unsigned ZERO_IDX = 63,
   parameter int unsigned LANES    = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             main_en,
   input  logic [AW-1:0]    main_addr,
   input  logic [XLEN-1:0]  main_data,
   input  logic [LANES-1:0] lane_en,
   input  logic [AW-1:0]    lane_idx  [LANES],
   input  logic [XLEN-1:0]  lane_data [LANES],
   output logic [XLEN-1:0]  regs_q    [NREGS],
   output logic             clash
);
   logic main_hit;
   assign main_hit = main_en && (main_addr != AW'(ZERO_IDX));

   always_comb begin
      clash = 1'b0;
      for (int k = 0; k < LANES; k++) begin
         if (main_hit && lane_en[k] && (lane_idx[k] == main_addr)) clash = 1'b1;
      end
   end

   for (genvar r = 0; r < NREGS; r++) begin : g_reg
      if (r == ZERO_IDX) begin : g_zero
         assign regs_q[r] = '0;
      end else begin : g_live
         logic [XLEN-1:0] q;
         logic [XLEN-1:0] nxt;
         logic            we;
         always_comb begin
            we  = 1'b0;
            nxt = q;
            for (int k = 0; k < LANES; k++) begin
               if (lane_en[k] && (lane_idx[k] == AW'(r))) begin
                  we  = 1'b1;
                  nxt = lane_data[k];
               end
            end
            // main port has priority over any side lane
            if (main_hit && (main_addr == AW'(r))) begin
               we  = 1'b1;
               nxt = main_data;
            end
         end
         always_ff @(posedge clk) begin
            if (rst)     q <= '0;
            else if (we) q <= nxt;
         end
         assign regs_q[r] = q;
      end
   end

   // R2
   main_write_chk: assert property (@(posedge clk) disable iff (rst)
      main_hit |=> regs_q[$past(main_addr)] == $past(main_data));

   // R8
   main_wins_chk: assert property (@(posedge clk) disable iff (rst)
      clash |=> regs_q[$past(main_addr)] == $past(main_data));

   for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      // R7 (also covers the merged lanes of R5 and R6)
      lane_apply_chk: assert property (@(posedge clk) disable iff (rst)
         (lane_en[k] && !(main_hit && main_addr == lane_idx[k]))
         |=> regs_q[$past(lane_idx[k])] == $past(lane_data[k]));
   end
endmodule

// File: rtl/arf_read_port.sv
module arf_read_port #(
   parameter int unsigned NREGS = 64,
   parameter int unsigned XLEN  = 64,
   parameter int unsigned HALF  = 32,
   parameter int unsigned AW    = 6
) (
   input  logic [AW-1:0]   addr,
   input  logic            narrow,
   input  logic [XLEN-1:0] regs [NREGS],
   output logic [XLEN-1:0] data
);
   localparam int unsigned EXT = XLEN - HALF;
   logic [XLEN-1:0] word;
   assign word = regs[addr];
   assign data = narrow ? {{EXT{1'b0}}, word[HALF-1:0]} : word;
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
   import arf_pkg::*;
#(
   parameter int unsigned NREGS     = 64,
   parameter int unsigned XLEN      = 64,
   parameter int unsigned HALF      = 32,
   parameter int unsigned ZERO_IDX  = 63,
   parameter int unsigned GBASE_IDX = 16,
   parameter int unsigned ACC_IDX   = 17,
   parameter int unsigned RET_IDX   = 18,
   parameter int unsigned FLAG_IDX  = 19,
   parameter int unsigned VBASE_IDX = 20,
   localparam int unsigned AW       = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic            wr_narrow,
   input  logic [AW-1:0]   wr_addr,
   input  logic [XLEN-1:0] wr_data,
   input  logic [AW-1:0]   rd_a_addr,
   input  logic            rd_a_narrow,
   output logic [XLEN-1:0] rd_a_data,
   input  logic [AW-1:0]   rd_b_addr,
   input  logic            rd_b_narrow,
   output logic [XLEN-1:0] rd_b_data,
   input  logic            acc_hi_we,
   input  logic [HALF-1:0] acc_hi_wd,
   input  logic            acc_lo_we,
   input  logic [HALF-1:0] acc_lo_wd,
   input  logic            tflag_we,
   input  logic            tflag_wd,
   input  logic            gbase_we,
   input  logic [HALF-1:0] gbase_wd,
   input  logic            ret_we,
   input  logic [HALF-1:0] ret_wd,
   input  logic            vbase_we,
   input  logic [HALF-1:0] vbase_wd,
   output logic [HALF-1:0] acc_hi_q,
   output logic [HALF-1:0] acc_lo_q,
   output logic            tflag_q,
   output logic [HALF-1:0] gbase_q,
   output logic [HALF-1:0] ret_q,
   output logic [HALF-1:0] vbase_q,
   output logic            clash
);
   localparam int unsigned EXT      = XLEN - HALF;
   localparam int unsigned RD_PORTS = 2;
   localparam bit IDX_DUP =
      (GBASE_IDX == ACC_IDX) || (GBASE_IDX == RET_IDX) || (GBASE_IDX == FLAG_IDX) ||
      (GBASE_IDX == VBASE_IDX) || (ACC_IDX == RET_IDX) || (ACC_IDX == FLAG_IDX) ||
      (ACC_IDX == VBASE_IDX) || (RET_IDX == FLAG_IDX) || (RET_IDX == VBASE_IDX) ||
      (FLAG_IDX == VBASE_IDX);
   localparam bit IDX_RANGE =
      (GBASE_IDX < NREGS) && (ACC_IDX < NREGS) && (RET_IDX < NREGS) &&
      (FLAG_IDX < NREGS) && (VBASE_IDX < NREGS) && (ZERO_IDX < NREGS);
   localparam bit IDX_ZERO =
      (GBASE_IDX == ZERO_IDX) || (ACC_IDX == ZERO_IDX) || (RET_IDX == ZERO_IDX) ||
      (FLAG_IDX == ZERO_IDX) || (VBASE_IDX == ZERO_IDX);

   // Elaboration-time parameter checks
   if (XLEN != 2 * HALF) begin : g_bad_width
      $error("alias_regfile: XLEN must be exactly twice HALF");
   end
   if (NREGS != (1 << AW)) begin : g_bad_depth
      $error("alias_regfile: NREGS must be a power of two");
   end
   if (!IDX_RANGE) begin : g_bad_range
      $error("alias_regfile: a fixed register index is outside the file");
   end
   if (IDX_DUP || IDX_ZERO) begin : g_bad_alias
      $error("alias_regfile: alias indices must be distinct and not the zero register");
   end

   // Main write data after width conversion
   logic [XLEN-1:0] main_data;
   assign main_data = wr_narrow ? {{EXT{wr_data[HALF-1]}}, wr_data[HALF-1:0]} : wr_data;

   logic [XLEN-1:0] regs_q [NREGS];

   // Side lanes
   logic [SIDE_LANES-1:0] lane_en;
   logic [XLEN-1:0]       lane_data [SIDE_LANES];
   logic [AW-1:0]         lane_idx  [SIDE_LANES];
   logic [WIDE_LANES-1:0] wide_we;
   logic [HALF-1:0]       wide_wd   [WIDE_LANES];

   assign lane_idx[LANE_ACC]   = AW'(ACC_IDX);
   assign lane_idx[LANE_FLAG]  = AW'(FLAG_IDX);
   assign lane_idx[LANE_GBASE] = AW'(GBASE_IDX);
   assign lane_idx[LANE_RET]   = AW'(RET_IDX);
   assign lane_idx[LANE_VBASE] = AW'(VBASE_IDX);

   assign wide_we    = {vbase_we, ret_we, gbase_we};
   assign wide_wd[0] = gbase_wd;
   assign wide_wd[1] = ret_wd;
   assign wide_wd[2] = vbase_wd;

   arf_side_merge #(
      .XLEN (XLEN),
      .HALF (HALF)
   ) u_merge (
      .acc_cur   (regs_q[ACC_IDX]),
      .flag_keep (regs_q[FLAG_IDX][XLEN-1:1]),
      .acc_hi_we (acc_hi_we),
      .acc_hi_wd (acc_hi_wd),
      .acc_lo_we (acc_lo_we),
      .acc_lo_wd (acc_lo_wd),
      .flag_we   (tflag_we),
      .flag_wd   (tflag_wd),
      .wide_we   (wide_we),
      .wide_wd   (wide_wd),
      .lane_en   (lane_en),
      .lane_data (lane_data)
   );

   arf_storage #(
      .NREGS    (NREGS),
      .XLEN     (XLEN),
      .AW       (AW),
      .ZERO_IDX (ZERO_IDX),
      .LANES    (SIDE_LANES)
   ) u_store (
      .clk       (clk),
      .rst       (rst),
      .main_en   (wr_en),
      .main_addr (wr_addr),
      .main_data (main_data),
      .lane_en   (lane_en),
      .lane_idx  (lane_idx),
      .lane_data (lane_data),
      .regs_q    (regs_q),
      .clash     (clash)
   );

   // Read ports
   logic [AW-1:0]   rp_addr [RD_PORTS];
   logic            rp_nar  [RD_PORTS];
   logic [XLEN-1:0] rp_data [RD_PORTS];

   assign rp_addr[0] = rd_a_addr;
   assign rp_nar[0]  = rd_a_narrow;
   assign rp_addr[1] = rd_b_addr;
   assign rp_nar[1]  = rd_b_narrow;
   assign rd_a_data  = rp_data[0];
   assign rd_b_data  = rp_data[1];

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      arf_read_port #(
         .NREGS (NREGS),
         .XLEN  (XLEN),
         .HALF  (HALF),
         .AW    (AW)
      ) u_rp (
         .addr   (rp_addr[p]),
         .narrow (rp_nar[p]),
         .regs   (regs_q),
         .data   (rp_data[p])
      );
   end

   // Architectural side views
   assign acc_hi_q = regs_q[ACC_IDX][XLEN-1:HALF];
   assign acc_lo_q = regs_q[ACC_IDX][HALF-1:0];
   assign tflag_q  = regs_q[FLAG_IDX][0];
   assign gbase_q  = regs_q[GBASE_IDX][HALF-1:0];
   assign ret_q    = regs_q[RET_IDX][HALF-1:0];
   assign vbase_q  = regs_q[VBASE_IDX][HALF-1:0];

   // R1
   zero_read_a_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_a_addr == AW'(ZERO_IDX)) |-> (rd_a_data == '0));

   // R1
   zero_read_b_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_b_addr == AW'(ZERO_IDX)) |-> (rd_b_data == '0));

   // R4
   narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
      rd_a_narrow |-> (rd_a_data[XLEN-1:HALF] == '0));

   // R3
   narrow_sext_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_narrow && wr_addr != AW'(ZERO_IDX))
      |=> regs_q[$past(wr_addr)][XLEN-1:HALF] == {EXT{regs_q[$past(wr_addr)][HALF-1]}});

   // R5
   acc_keep_lo_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_hi_we && !acc_lo_we && !(wr_en && wr_addr == AW'(ACC_IDX)))
      |=> $stable(acc_lo_q));

   // R6
   flag_only_chk: assert property (@(posedge clk) disable iff (rst)
      (tflag_we && !(wr_en && wr_addr == AW'(FLAG_IDX)))
      |=> $stable(regs_q[FLAG_IDX][XLEN-1:1]));

   // R7
   gbase_sext_chk: assert property (@(posedge clk) disable iff (rst)
      (gbase_we && !(wr_en && wr_addr == AW'(GBASE_IDX)))
      |=> regs_q[GBASE_IDX][XLEN-1:HALF] == {EXT{regs_q[GBASE_IDX][HALF-1]}});
endmodule

// File: tb/tb_alias_regfile.sv
`timescale 1ns/1ps
module tb_alias_regfile;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en, wr_narrow;
   logic [5:0]  wr_addr;
   logic [63:0] wr_data;
   logic [5:0]  rd_a_addr, rd_b_addr;
   logic        rd_a_narrow, rd_b_narrow;
   logic [63:0] rd_a_data, rd_b_data;
   logic        acc_hi_we, acc_lo_we, tflag_we, tflag_wd, gbase_we, ret_we, vbase_we;
   logic [31:0] acc_hi_wd, acc_lo_wd, gbase_wd, ret_wd, vbase_wd;
   logic [31:0] acc_hi_q, acc_lo_q, gbase_q, ret_q, vbase_q;
   logic        tflag_q, clash;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [63:0] m [64];

   always #2.5 clk = ~clk;

   alias_regfile dut (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_narrow(wr_narrow), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_a_addr(rd_a_addr), .rd_a_narrow(rd_a_narrow), .rd_a_data(rd_a_data),
      .rd_b_addr(rd_b_addr), .rd_b_narrow(rd_b_narrow), .rd_b_data(rd_b_data),
      .acc_hi_we(acc_hi_we), .acc_hi_wd(acc_hi_wd), .acc_lo_we(acc_lo_we), .acc_lo_wd(acc_lo_wd),
      .tflag_we(tflag_we), .tflag_wd(tflag_wd),
      .gbase_we(gbase_we), .gbase_wd(gbase_wd), .ret_we(ret_we), .ret_wd(ret_wd),
      .vbase_we(vbase_we), .vbase_wd(vbase_wd),
      .acc_hi_q(acc_hi_q), .acc_lo_q(acc_lo_q), .tflag_q(tflag_q),
      .gbase_q(gbase_q), .ret_q(ret_q), .vbase_q(vbase_q), .clash(clash)
   );

   function automatic logic [63:0] sx(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   function automatic logic [63:0] pat(input int i, input logic [63:0] salt);
      return (64'(i + 1) * 64'h9E37_79B9_7F4A_7C15) ^ salt;
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic idle();
      wr_en = 0; wr_narrow = 0; wr_addr = '0; wr_data = '0;
      acc_hi_we = 0; acc_lo_we = 0; tflag_we = 0; gbase_we = 0; ret_we = 0; vbase_we = 0;
      acc_hi_wd = '0; acc_lo_wd = '0; tflag_wd = 0; gbase_wd = '0; ret_wd = '0; vbase_wd = '0;
   endtask

   task automatic commit();
      @(posedge clk);
      #1 idle();
   endtask

   task automatic main_wr(input int a, input logic [63:0] d, input bit nar, input string tag);
      @(negedge clk);
      wr_en = 1; wr_addr = 6'(a); wr_data = d; wr_narrow = nar;
      rd_b_addr = 6'(a); rd_b_narrow = 0;
      #1;
      chk({tag, " old value during write cycle (R2)"}, rd_b_data, m[a]);
      chk({tag, " no clash without side write (R8)"}, 64'(clash), 64'd0);
      commit();
      if (a != 63) m[a] = nar ? sx(d[31:0]) : d;
   endtask

   task automatic rd_chk(input string tag, input int a);
      @(negedge clk);
      rd_a_addr = 6'(a); rd_a_narrow = 0;
      #1 chk(tag, rd_a_data, m[a]);
   endtask

   task automatic sweep(input string tag, input bit nar);
      @(negedge clk);
      for (int i = 0; i < 64; i++) begin
         rd_a_addr = 6'(i); rd_a_narrow = nar;
         rd_b_addr = 6'(63 - i); rd_b_narrow = 0;
         #1;
         chk({tag, " port A"}, rd_a_data, nar ? {32'd0, m[i][31:0]} : m[i]);
         chk({tag, " port B"}, rd_b_data, m[63 - i]);
      end
   endtask

   task automatic side_chk(input string tag);
      #0.5;
      chk({tag, " acc_hi_q (R5)"}, 64'(acc_hi_q), 64'(m[17][63:32]));
      chk({tag, " acc_lo_q (R5)"}, 64'(acc_lo_q), 64'(m[17][31:0]));
      chk({tag, " tflag_q (R6)"},  64'(tflag_q),  64'(m[19][0]));
      chk({tag, " gbase_q (R7)"},  64'(gbase_q),  64'(m[16][31:0]));
      chk({tag, " ret_q (R7)"},    64'(ret_q),    64'(m[18][31:0]));
      chk({tag, " vbase_q (R7)"},  64'(vbase_q),  64'(m[20][31:0]));
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) m[i] = '0;
      rst = 1; idle();
      rd_a_addr = '0; rd_b_addr = '0; rd_a_narrow = 0; rd_b_narrow = 0;
      repeat (3) @(posedge clk);
      #1 rst = 0;

      // R9: load a value, then reset and expect a cleared file
      main_wr(5, pat(5, 64'h1), 0, "R9 prep");
      main_wr(17, pat(17, 64'h2), 0, "R9 prep");
      @(negedge clk); rst = 1;
      repeat (2) @(posedge clk);
      #1 rst = 0;
      for (int i = 0; i < 64; i++) m[i] = '0;
      sweep("R9 cleared", 0);
      side_chk("R9 cleared");

      // R2 / R1: full writes to every register including the zero register
      for (int i = 0; i < 64; i++) main_wr(i, pat(i, 64'hC3C3_0000_5A5A_FFFF), 0, "R2 full write");
      sweep("R2 R1 full readback", 0);

      // R4: narrow reads
      sweep("R4 narrow read", 1);

      // R3: narrow writes, both sign cases appear across the pattern
      for (int i = 0; i < 64; i++) main_wr(i, pat(i, 64'h0123_4567_89AB_CDEF), 1, "R3 narrow write");
      sweep("R3 R1 sign-extended readback", 0);
      main_wr(7, 64'hFFFF_FFFF_8000_0000, 1, "R3 negative");
      rd_chk("R3 negative word", 7);
      main_wr(8, 64'h8000_0000_7FFF_FFFF, 1, "R3 positive");
      rd_chk("R3 positive word", 8);

      // R5: accumulator halves
      main_wr(17, 64'h1111_2222_3333_4444, 0, "R5 prep");
      @(negedge clk); acc_hi_we = 1; acc_hi_wd = 32'hDEAD_BEEF; commit();
      m[17] = {32'hDEAD_BEEF, m[17][31:0]};
      rd_chk("R5 high write keeps low", 17); side_chk("R5 high");
      @(negedge clk); acc_lo_we = 1; acc_lo_wd = 32'h8765_4321; commit();
      m[17] = {m[17][63:32], 32'h8765_4321};
      rd_chk("R5 low write keeps high", 17); side_chk("R5 low");
      @(negedge clk); acc_hi_we = 1; acc_hi_wd = 32'h0BAD_F00D; acc_lo_we = 1; acc_lo_wd = 32'hFACE_0001; commit();
      m[17] = {32'h0BAD_F00D, 32'hFACE_0001};
      rd_chk("R5 both halves", 17); side_chk("R5 both");

      // R6: flag bit only
      main_wr(19, 64'hA5A5_5A5A_F0F0_0F0E, 0, "R6 prep");
      @(negedge clk); tflag_we = 1; tflag_wd = 1; commit();
      m[19][0] = 1'b1;
      rd_chk("R6 flag set", 19); side_chk("R6 set");
      @(negedge clk); tflag_we = 1; tflag_wd = 0; commit();
      m[19][0] = 1'b0;
      rd_chk("R6 flag clear", 19); side_chk("R6 clear");

      // R7: word-wide aliases, both signs
      @(negedge clk);
      gbase_we = 1; gbase_wd = 32'h8000_0001;
      ret_we = 1;   ret_wd = 32'h7FFF_FFF0;
      vbase_we = 1; vbase_wd = 32'hC000_0000;
      commit();
      m[16] = sx(32'h8000_0001); m[18] = sx(32'h7FFF_FFF0); m[20] = sx(32'hC000_0000);
      rd_chk("R7 gbase sext", 16); rd_chk("R7 ret sext", 18); rd_chk("R7 vbase sext", 20);
      side_chk("R7 round 1");
      @(negedge clk);
      gbase_we = 1; gbase_wd = 32'h0000_1234;
      ret_we = 1;   ret_wd = 32'hFFFF_0000;
      commit();
      m[16] = sx(32'h0000_1234); m[18] = sx(32'hFFFF_0000);
      rd_chk("R7 gbase sext 2", 16); rd_chk("R7 ret sext 2", 18); rd_chk("R7 vbase kept", 20);
      side_chk("R7 round 2");

      // R8: collisions, main write wins and clash is raised
      @(negedge clk);
      wr_en = 1; wr_addr = 6'd17; wr_data = 64'h0102_0304_0506_0708; wr_narrow = 0;
      acc_hi_we = 1; acc_hi_wd = 32'hFFFF_FFFF; acc_lo_we = 1; acc_lo_wd = 32'hEEEE_EEEE;
      #1 chk("R8 clash on accumulator", 64'(clash), 64'd1);
      commit(); m[17] = 64'h0102_0304_0506_0708;
      rd_chk("R8 main wins accumulator", 17); side_chk("R8 acc");

      @(negedge clk);
      wr_en = 1; wr_addr = 6'd16; wr_data = 64'h0000_0000_9000_0000; wr_narrow = 1;
      gbase_we = 1; gbase_wd = 32'h0000_0055;
      #1 chk("R8 clash on gbase", 64'(clash), 64'd1);
      commit(); m[16] = sx(32'h9000_0000);
      rd_chk("R8 narrow main wins gbase", 16);

      @(negedge clk);
      wr_en = 1; wr_addr = 6'd19; wr_data = 64'h0000_0000_0000_0002; wr_narrow = 0;
      tflag_we = 1; tflag_wd = 1;
      #1 chk("R8 clash on flag", 64'(clash), 64'd1);
      commit(); m[19] = 64'h2;
      rd_chk("R8 main wins flag", 19); side_chk("R8 flag");

      @(negedge clk);
      wr_en = 1; wr_addr = 6'd5; wr_data = 64'hCAFE_0000_BABE_0000; wr_narrow = 0;
      ret_we = 1; ret_wd = 32'h8888_0000;
      #1 chk("R8 no clash on distinct targets", 64'(clash), 64'd0);
      commit(); m[5] = 64'hCAFE_0000_BABE_0000; m[18] = sx(32'h8888_0000);
      rd_chk("R8 main applied", 5); rd_chk("R8 side applied", 18);

      @(negedge clk);
      wr_en = 1; wr_addr = 6'd63; wr_data = '1; wr_narrow = 0;
      vbase_we = 1; vbase_wd = 32'h0000_0F00;
      #1 chk("R8 no clash with zero-register write", 64'(clash), 64'd0);
      commit(); m[20] = sx(32'h0000_0F00);
      rd_chk("R1 zero register after write", 63); rd_chk("R8 side applied vbase", 20);

      sweep("final state", 0);
      done = 1'b1;
      finish_run();
   end
endmodule